// File: doc/BRIEF.md
# Dual-Port Pipelined Burst RAM

A true dual-port synchronous RAM with two independent ports, called left and right. Each port has its own clock and can read or write any word at any time, including the word the other port is using. Every input of a port is captured on that port's rising clock edge. Read data then passes through an output register, so a read costs one extra clock. The word is split into four 9-bit byte lanes, and each lane has its own enable.

Each port holds a local address counter. In a given cycle the counter can be cleared, loaded from the address pins or advanced by one word, and the access in that same cycle uses the counter's new value. A burst therefore needs one load followed by a run of advance cycles, with no address generation outside the block. Two chip-select inputs per port must both be active for an access to take place, which allows several blocks to share a bus for depth expansion. Instead of high-impedance pins, each output lane comes with a drive-enable bit, so the pad ring can build its own tri-state buffers.

The depth is 2^ADDR_W words. ADDR_W = 15 gives 32768 words, and the default is kept smaller so that elaboration stays light.

Top module: `dpram_dual_burst`

## Requirements
- R1: While reset is held and after it is released, no lane of either port is driven. Both address counters start at 0, so an access made without any counter command goes to word 0.
- R2: With the load input low (and clear high), the counter takes the address pins on the capturing edge, and that cycle's access uses the loaded address.
- R3: With clear and load high and advance low, the counter steps up by one word, and that cycle's access uses the new value. From 2^ADDR_W-1 it wraps to 0.
- R4: The counter commands rank as clear, then load, then advance. With all three high the counter holds, and a repeated access reuses the same word.
- R5: A selected read captured on edge k drives its data after edge k+1, and stays driven until the next capture changes the pipeline. Reads on consecutive cycles stream one word per cycle.
- R6: Lane i covers data bits [9i+8:9i], for i = 0..3. A write changes only the lanes whose active-low enable bit be_ni[i] is 0. All other lanes keep their old contents.
- R7: On a read, only the lanes whose be_ni bit was 0 at capture are driven.
- R8: An access happens only when both bits of ce_ni are 0. Any other value stores nothing and drives nothing.
- R9: drv_o[i] is 1 only when oe_ni is currently low (not registered), the last capture was a selected read, and lane i was enabled. Undriven lanes of data_o read as 0.
- R10: A word written by one port is returned by a read on the other port that is captured on the edge after the write was captured. Both ports may read the same word in the same cycle.
- R11: If both ports write the same word on the same edge, the right port's data is stored in every lane both ports enable. Lanes enabled by only one port take that port's data.
- R12: A read captured on the same edge as the other port's write to the same word returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_addr_i | input | ADDR_W | Left address pins, used on load |
| l_ld_ni | input | 1 | Left counter load, active low |
| l_inc_ni | input | 1 | Left counter advance, active low |
| l_clr_ni | input | 1 | Left counter clear, active low |
| l_we_ni | input | 1 | Left write select, low = write, high = read |
| l_be_ni | input | 4 | Left lane enables, active low |
| l_ce_ni | input | 2 | Left chip selects, both low to select |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_data_i | input | 36 | Left write data |
| l_data_o | output | 36 | Left read data, 0 in undriven lanes |
| l_drv_o | output | 4 | Left per-lane drive enables |
| r_addr_i | input | ADDR_W | Right address pins, used on load |
| r_ld_ni | input | 1 | Right counter load, active low |
| r_inc_ni | input | 1 | Right counter advance, active low |
| r_clr_ni | input | 1 | Right counter clear, active low |
| r_we_ni | input | 1 | Right write select, low = write, high = read |
| r_be_ni | input | 4 | Right lane enables, active low |
| r_ce_ni | input | 2 | Right chip selects, both low to select |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_data_i | input | 36 | Right write data |
| r_data_o | output | 36 | Right read data, 0 in undriven lanes |
| r_drv_o | output | 4 | Right per-lane drive enables |

## Verification
The counter and the access registers update on the capturing edge k. A write reaches the array on edge k+1, and read data and drive enables appear after edge k+1, so a read issued just after a write sees the new word one edge later. The bench advances a behavioural model on every rising edge: reads first, then writes in left-then-right order, then counter and capture updates. It compares both ports on the following falling edge, which lands every comparison in the cycle its result is due. The output enable is combinational, so the model reads its present value when each comparison is made.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 9;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_t;
endpackage

// File: rtl/dpram_addr_cnt.sv
module dpram_addr_cnt
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              load_ni,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  cnt_op_t op;

  // clear > load > advance
  always_comb begin
    if (!clr_ni)       op = CNT_CLR;
    else if (!load_ni) op = CNT_LOAD;
    else if (!adv_ni)  op = CNT_INC;
    else               op = CNT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else begin
      unique case (op)
        CNT_CLR:  addr_o <= '0;
        CNT_LOAD: addr_o <= addr_i;
        CNT_INC:  addr_o <= addr_o + ADDR_W'(1);
        CNT_HOLD: addr_o <= addr_o;
      endcase
    end
  end

  // R4
  clr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (addr_o == '0));
  // R2
  load_over_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (addr_o == $past(addr_i)));
  // R3
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !adv_ni) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && adv_ni) |=> $stable(addr_o));
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ld_ni,
  input  logic                    inc_ni,
  input  logic                    clr_ni,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        be_ni,
  input  logic [1:0]              ce_ni,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic [LANES-1:0]        drv_o,
  output logic [ADDR_W-1:0]       acc_addr_o,
  output logic [LANES-1:0]        wr_lanes_o,
  output logic [LANES*LANE_W-1:0] wr_data_o,
  input  logic [LANES*LANE_W-1:0] rd_data_i
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic              sel_q, wr_q, rd_vld_q;
  logic [LANES-1:0]  be_q, rd_be_q;
  logic [WORD_W-1:0] din_q, dout_q;

  dpram_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .load_ni (ld_ni),
    .adv_ni  (inc_ni),
    .addr_i  (addr_i),
    .addr_o  (acc_addr_o)
  );

  // capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      be_q  <= '0;
      din_q <= '0;
    end else begin
      sel_q <= (ce_ni == 2'b00);
      wr_q  <= ~we_ni;
      be_q  <= ~be_ni;
      din_q <= data_i;
    end
  end

  assign wr_lanes_o = (sel_q && wr_q) ? be_q : '0;
  assign wr_data_o  = din_q;

  // output register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      rd_be_q  <= '0;
      dout_q   <= '0;
    end else begin
      rd_vld_q <= sel_q && !wr_q;
      rd_be_q  <= be_q;
      if (sel_q && !wr_q) dout_q <= rd_data_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign drv_o[g] = !oe_ni && rd_vld_q && rd_be_q[g];
    assign data_o[g*LANE_W +: LANE_W] = drv_o[g] ? dout_q[g*LANE_W +: LANE_W] : '0;
  end

  // R8
  desel_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni != 2'b00) |=> (wr_lanes_o == '0));
  // R5
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ce_ni == 2'b00) && we_ni) |=> ##1 rd_vld_q);
  // R8
  desel_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni != 2'b00) |=> ##1 !rd_vld_q);
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_lanes_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [LANES-1:0]        wr_tog_i,
  input  logic [ADDR_W-1:0]       rd_a_addr_i,
  output logic [LANES*LANE_W-1:0] rd_a_data_o,
  output logic [LANES-1:0]        rd_a_tog_o,
  input  logic [ADDR_W-1:0]       rd_b_addr_i,
  output logic [LANES*LANE_W-1:0] rd_b_data_o,
  output logic [LANES-1:0]        rd_b_tog_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [LANES-1:0]  tog_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++)
      if (wr_lanes_i[l]) mem_q[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
  end

  // per-lane ownership bit, xor-ed with the peer's to pick the newest copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) tog_q[a] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (wr_lanes_i[l]) tog_q[wr_addr_i][l] <= wr_tog_i[l];
    end
  end

  assign rd_a_data_o = mem_q[rd_a_addr_i];
  assign rd_a_tog_o  = tog_q[rd_a_addr_i];
  assign rd_b_data_o = mem_q[rd_b_addr_i];
  assign rd_b_tog_o  = tog_q[rd_b_addr_i];
endmodule

// File: rtl/dpram_dual_burst.sv
module dpram_dual_burst
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                    clk_l_i,
  input  logic                    clk_r_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       l_addr_i,
  input  logic                    l_ld_ni,
  input  logic                    l_inc_ni,
  input  logic                    l_clr_ni,
  input  logic                    l_we_ni,
  input  logic [LANES-1:0]        l_be_ni,
  input  logic [1:0]              l_ce_ni,
  input  logic                    l_oe_ni,
  input  logic [LANES*LANE_W-1:0] l_data_i,
  output logic [LANES*LANE_W-1:0] l_data_o,
  output logic [LANES-1:0]        l_drv_o,
  input  logic [ADDR_W-1:0]       r_addr_i,
  input  logic                    r_ld_ni,
  input  logic                    r_inc_ni,
  input  logic                    r_clr_ni,
  input  logic                    r_we_ni,
  input  logic [LANES-1:0]        r_be_ni,
  input  logic [1:0]              r_ce_ni,
  input  logic                    r_oe_ni,
  input  logic [LANES*LANE_W-1:0] r_data_i,
  output logic [LANES*LANE_W-1:0] r_data_o,
  output logic [LANES-1:0]        r_drv_o
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [ADDR_W-1:0] l_acc, r_acc;
  logic [LANES-1:0]  l_wl, r_wl, l_wl_eff, l_tog_new, r_tog_new;
  logic [WORD_W-1:0] l_wd, r_wd, l_rd, r_rd;
  logic [WORD_W-1:0] sl_at_l, sl_at_r, sr_at_l, sr_at_r;
  logic [LANES-1:0]  tl_at_l, tl_at_r, tr_at_l, tr_at_r;

  dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .addr_i(l_addr_i), .ld_ni(l_ld_ni), .inc_ni(l_inc_ni),
    .clr_ni(l_clr_ni), .we_ni(l_we_ni), .be_ni(l_be_ni), .ce_ni(l_ce_ni), .oe_ni(l_oe_ni),
    .data_i(l_data_i), .data_o(l_data_o), .drv_o(l_drv_o), .acc_addr_o(l_acc),
    .wr_lanes_o(l_wl), .wr_data_o(l_wd), .rd_data_i(l_rd)
  );

  dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .addr_i(r_addr_i), .ld_ni(r_ld_ni), .inc_ni(r_inc_ni),
    .clr_ni(r_clr_ni), .we_ni(r_we_ni), .be_ni(r_be_ni), .ce_ni(r_ce_ni), .oe_ni(r_oe_ni),
    .data_i(r_data_i), .data_o(r_data_o), .drv_o(r_drv_o), .acc_addr_o(r_acc),
    .wr_lanes_o(r_wl), .wr_data_o(r_wd), .rd_data_i(r_rd)
  );

  // same-edge collision: left drops lanes the right port also writes
  assign l_wl_eff  = l_wl & ((l_acc == r_acc) ? ~r_wl : {LANES{1'b1}});
  assign l_tog_new = tr_at_l;
  assign r_tog_new = ~tl_at_r;

  dpram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .wr_addr_i(l_acc), .wr_lanes_i(l_wl_eff),
    .wr_data_i(l_wd), .wr_tog_i(l_tog_new),
    .rd_a_addr_i(l_acc), .rd_a_data_o(sl_at_l), .rd_a_tog_o(tl_at_l),
    .rd_b_addr_i(r_acc), .rd_b_data_o(sl_at_r), .rd_b_tog_o(tl_at_r)
  );

  dpram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .wr_addr_i(r_acc), .wr_lanes_i(r_wl),
    .wr_data_i(r_wd), .wr_tog_i(r_tog_new),
    .rd_a_addr_i(l_acc), .rd_a_data_o(sr_at_l), .rd_a_tog_o(tr_at_l),
    .rd_b_addr_i(r_acc), .rd_b_data_o(sr_at_r), .rd_b_tog_o(tr_at_r)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign l_rd[g*LANE_W +: LANE_W] = (tl_at_l[g] ^ tr_at_l[g]) ?
                                      sr_at_l[g*LANE_W +: LANE_W] : sl_at_l[g*LANE_W +: LANE_W];
    assign r_rd[g*LANE_W +: LANE_W] = (tl_at_r[g] ^ tr_at_r[g]) ?
                                      sr_at_r[g*LANE_W +: LANE_W] : sl_at_r[g*LANE_W +: LANE_W];
  end
endmodule

// File: tb/tb_dpram_dual_burst.sv
module tb_dpram_dual_burst;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr [2];
  logic          ld_n [2], inc_n [2], clr_n [2], we_n [2], oe_n [2];
  logic [3:0]    be_n [2];
  logic [1:0]    ce_n [2];
  logic [35:0]   din  [2];
  logic [35:0]   dout [2];
  logic [3:0]    drv  [2];

  dpram_dual_burst #(.ADDR_W(AW)) dut (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_n),
    .l_addr_i(addr[0]), .l_ld_ni(ld_n[0]), .l_inc_ni(inc_n[0]), .l_clr_ni(clr_n[0]),
    .l_we_ni(we_n[0]), .l_be_ni(be_n[0]), .l_ce_ni(ce_n[0]), .l_oe_ni(oe_n[0]),
    .l_data_i(din[0]), .l_data_o(dout[0]), .l_drv_o(drv[0]),
    .r_addr_i(addr[1]), .r_ld_ni(ld_n[1]), .r_inc_ni(inc_n[1]), .r_clr_ni(clr_n[1]),
    .r_we_ni(we_n[1]), .r_be_ni(be_n[1]), .r_ce_ni(ce_n[1]), .r_oe_ni(oe_n[1]),
    .r_data_i(din[1]), .r_data_o(dout[1]), .r_drv_o(drv[1])
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  logic [35:0] rmem  [DEPTH];
  logic [3:0]  known [DEPTH];
  int          m_cnt [2];
  bit          m_sel [2], m_wr [2], m_vld [2];
  logic [3:0]  m_be [2], m_rbe [2], m_kn [2];
  logic [35:0] m_din [2], m_dout [2];

  initial begin
    for (int a = 0; a < DEPTH; a++) known[a] = 4'b0;
    for (int p = 0; p < 2; p++) begin
      m_cnt[p] = 0; m_sel[p] = 0; m_wr[p] = 0; m_vld[p] = 0;
      m_be[p] = 0; m_rbe[p] = 0; m_kn[p] = 0; m_din[p] = 0; m_dout[p] = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_cnt[p] = 0; m_sel[p] = 0; m_wr[p] = 0; m_vld[p] = 0; m_rbe[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_vld[p] = m_sel[p] && !m_wr[p];
        m_rbe[p] = m_be[p];
        if (m_vld[p]) begin
          m_dout[p] = rmem[m_cnt[p]];
          m_kn[p]   = known[m_cnt[p]];
        end
      end
      for (int p = 0; p < 2; p++)   // right applied last: wins collisions
        if (m_sel[p] && m_wr[p])
          for (int l = 0; l < 4; l++)
            if (m_be[p][l]) begin
              rmem[m_cnt[p]][l*9 +: 9] = m_din[p][l*9 +: 9];
              known[m_cnt[p]][l] = 1'b1;
            end
      for (int p = 0; p < 2; p++) begin
        if (!clr_n[p])      m_cnt[p] = 0;
        else if (!ld_n[p])  m_cnt[p] = int'(addr[p]);
        else if (!inc_n[p]) m_cnt[p] = (m_cnt[p] + 1) % DEPTH;
        m_sel[p] = (ce_n[p] == 2'b00);
        m_wr[p]  = !we_n[p];
        m_be[p]  = ~be_n[p];
        m_din[p] = din[p];
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s got %h exp %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int p = 0; p < 2; p++) begin
        logic [3:0]  e_drv;
        logic [35:0] e_dat, mask;
        e_drv = (!oe_n[p] && m_vld[p]) ? m_rbe[p] : 4'b0;
        e_dat = '0;
        mask  = '0;
        for (int l = 0; l < 4; l++) begin
          if (!e_drv[l]) mask[l*9 +: 9] = 9'h1FF;
          else if (m_kn[p][l]) begin
            mask[l*9 +: 9]  = 9'h1FF;
            e_dat[l*9 +: 9] = m_dout[p][l*9 +: 9];
          end
        end
        check(drv[p] == e_drv, (p == 0) ? "left drv" : "right drv", 36'(drv[p]), 36'(e_drv));
        check((dout[p] & mask) == e_dat, (p == 0) ? "left data" : "right data", dout[p] & mask, e_dat);
      end
    end
  end

  task automatic idle(input int p);
    ce_n[p] = 2'b11; we_n[p] = 1'b1; be_n[p] = 4'hF; ld_n[p] = 1'b1;
    inc_n[p] = 1'b1; clr_n[p] = 1'b1; oe_n[p] = 1'b0; addr[p] = '0; din[p] = '0;
  endtask

  task automatic acc(input int p, input bit wr, input int a, input logic [35:0] d,
                     input logic [3:0] ben, input bit load);
    ce_n[p] = 2'b00; we_n[p] = !wr; be_n[p] = ben; ld_n[p] = !load;
    inc_n[p] = 1'b1; clr_n[p] = 1'b1; addr[p] = AW'(a); din[p] = d;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [35:0] pat(input int i);
    return 36'h9_0000_0000 ^ 36'(i * 32'h0001_3579) ^ 36'(i << 20);
  endfunction

  initial begin
    idle(0); idle(1);
    cur_req = "R1";
    step(3);
    rst_n = 1'b1;
    // R1: counter at 0, no command: write via left, read via right
    ce_n[0] = 2'b00; we_n[0] = 1'b0; be_n[0] = 4'h0; din[0] = 36'h1_2345_6789;
    step(1); idle(0);
    ce_n[1] = 2'b00; we_n[1] = 1'b1; be_n[1] = 4'h0;
    step(1); idle(1); step(3);

    // R2 and R5: loaded writes, then back-to-back loaded reads
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin acc(0, 1, 16 + i, pat(i), 4'h0, 1); step(1); end
    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin acc(0, 0, 16 + i, '0, 4'h0, 1); step(1); end
    idle(0); step(3);

    // R3: burst write/read with advance, and wrap
    cur_req = "R3";
    acc(0, 1, 200, pat(40), 4'h0, 1); step(1);
    for (int i = 1; i < 6; i++) begin ld_n[0] = 1'b1; inc_n[0] = 1'b0; din[0] = pat(40 + i); step(1); end
    idle(0);
    acc(1, 0, 200, '0, 4'h0, 1); step(1);
    for (int i = 1; i < 6; i++) begin ld_n[1] = 1'b1; inc_n[1] = 1'b0; step(1); end
    idle(1); step(2);
    acc(0, 1, DEPTH - 1, pat(60), 4'h0, 1); step(1);
    ld_n[0] = 1'b1; inc_n[0] = 1'b0; din[0] = pat(61); step(1); idle(0);
    acc(1, 0, DEPTH - 1, '0, 4'h0, 1); step(1);
    ld_n[1] = 1'b1; inc_n[1] = 1'b0; step(1); idle(1); step(3);

    // R4: clear over load over advance, hold
    cur_req = "R4";
    acc(0, 1, 300, pat(70), 4'h0, 1); clr_n[0] = 1'b0; inc_n[0] = 1'b0; step(1);
    acc(0, 1, 301, pat(71), 4'h0, 1); inc_n[0] = 1'b0; step(1);
    acc(0, 1, 0, pat(72), 4'h0, 0); step(1); idle(0);
    acc(1, 0, 0, '0, 4'h0, 1); step(1);
    acc(1, 0, 301, '0, 4'h0, 1); step(1);
    acc(1, 0, 302, '0, 4'h0, 0); step(1);
    idle(1); step(3);

    // R6: lane masked write
    cur_req = "R6";
    acc(0, 1, 400, 36'hF_FFFF_FFFF, 4'h0, 1); step(1);
    acc(0, 1, 400, 36'h0_0000_0000, 4'b0101, 1); step(1);
    acc(0, 0, 400, '0, 4'h0, 1); step(1); idle(0); step(3);

    // R7: lane gated read
    cur_req = "R7";
    acc(1, 0, 400, '0, 4'b1001, 1); step(1); idle(1); step(3);

    // R8: deselected write and read
    cur_req = "R8";
    acc(0, 1, 400, 36'h5_5555_5555, 4'h0, 1); ce_n[0] = 2'b01; step(1);
    acc(0, 1, 400, 36'h5_5555_5555, 4'h0, 1); ce_n[0] = 2'b10; step(1);
    acc(0, 0, 400, '0, 4'h0, 1); ce_n[0] = 2'b10; step(1);
    acc(0, 0, 400, '0, 4'h0, 1); step(1); idle(0); step(3);

    // R9: output enable is combinational
    cur_req = "R9";
    acc(0, 0, 16, '0, 4'h0, 1); oe_n[0] = 1'b1; step(1);
    step(1);
    oe_n[0] = 1'b0; step(1);
    idle(0); step(3);

    // R10: cross-port visibility, shared reads
    cur_req = "R10";
    acc(0, 1, 500, pat(80), 4'h0, 1); step(1); idle(0);
    acc(1, 0, 500, '0, 4'h0, 1); step(1);
    acc(1, 1, 501, pat(81), 4'h0, 1); step(1); idle(1);
    acc(0, 0, 501, '0, 4'h0, 1); step(1);
    acc(0, 0, 500, '0, 4'h0, 1); acc(1, 0, 500, '0, 4'h0, 1); step(1);
    idle(0); idle(1); step(3);

    // R12: read-before-write on same edge
    cur_req = "R12";
    acc(0, 1, 500, pat(90), 4'h0, 1); acc(1, 0, 500, '0, 4'h0, 1); step(1); idle(0);
    step(1); idle(1); step(3);

    // R11: same-edge write collision
    cur_req = "R11";
    acc(0, 1, 600, pat(100), 4'h0, 1); acc(1, 1, 600, pat(101), 4'b1100, 1); step(1);
    acc(0, 1, 601, pat(102), 4'h0, 1); acc(1, 1, 601, pat(103), 4'h0, 1); step(1);
    idle(1);
    acc(0, 1, 602, pat(104), 4'b0011, 1); acc(1, 1, 602, pat(105), 4'b1001, 1); step(1);
    idle(0); idle(1);
    acc(0, 1, 603, pat(106), 4'h0, 1); step(1);   // right then left later: left wins
    idle(0); acc(1, 1, 603, pat(107), 4'h0, 1); step(1);
    idle(1); acc(0, 1, 603, pat(108), 4'b1110, 1); step(1); idle(0);
    acc(1, 0, 600, '0, 4'h0, 1); step(1);
    acc(1, 0, 601, '0, 4'h0, 1); step(1);
    acc(1, 0, 602, '0, 4'h0, 1); step(1);
    acc(1, 0, 603, '0, 4'h0, 1); step(1);
    idle(1); step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL %s watchdog got timeout exp completion", cur_req);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule